// File: doc/BRIEF.md
# DDR2 Burst Latency Scheduler

This block sits between a DDR2 command issuer and the data paths of a memory controller. It takes each READ or WRITE on the cycle it is issued to the memory, together with its bank, column and auto-precharge flag. From the programmed CAS latency and posted additive latency it works out the controller-clock cycle in which the burst's data phase opens. It then raises data-valid, strobe-enable and last-beat indications for the read return path and the write drive path. Data is counted at two beats per controller cycle, so a 4-beat burst takes two cycles and an 8-beat burst takes four.

Read latency is additive latency plus CAS latency, and write latency is one cycle less. Pending bursts wait in a per-direction delay line deep enough for the largest read latency, so commands that overlap in time keep their own schedule. An 8-beat burst can be cut short by a command of the same direction issued two cycles later. Spacings that would split a beat pair are rejected. When a burst that asked for auto-precharge completes, the block requests a precharge of that bank.

Top module: `dlat_sched`

## Requirements
- R1: `cfg_cas` gives the CAS latency in cycles and accepts 3 to 7. A READ sampled at clock edge E has `rd_valid` high from edge E+RL, where RL = `cfg_add` + `cfg_cas` as last accepted.
- R2: `cfg_add` gives the additive latency in cycles and accepts 0 to 5. It adds one-for-one to the start cycle of both reads and writes.
- R3: A configuration write (`cfg_we`) with `cfg_cas` outside 3..7 or `cfg_add` above 5 leaves all three settings (CAS, additive, burst length) unchanged. It raises `cfg_err` for the single cycle after the edge that sampled it. A legal write takes effect for commands sampled on later edges.
- R4: A WRITE sampled at edge E has `wr_valid` high from edge E+RL-1.
- R5: `cfg_bl8`=1 selects 8-beat bursts (valid for four cycles) and 0 selects 4-beat bursts (two cycles). `rd_last`/`wr_last` mark the final cycle of a burst that completes. The burst length is fixed when the command is accepted.
- R6: `rd_dqs_en`/`wr_dqs_en` rise one cycle before the first data cycle of a burst (preamble) and stay high through its last data cycle.
- R7: A same-direction command sampled two edges after an 8-beat command truncates it. The old burst gives two data cycles and no last indication, and the new burst follows without a gap.
- R8: A same-direction command sampled one edge after the last accepted one, or three edges after an accepted 8-beat one, is ignored and produces no data. It raises `cmd_err` for the single cycle after the edge that sampled it.
- R9: Address bit 10 requests auto-precharge. In the cycle after the last data cycle of such a burst, `rd_pre`/`wr_pre` pulse for one cycle with the burst's bank on `rd_pre_bank`/`wr_pre_bank`. A truncated burst requests nothing.
- R10: Address bits 9..0 are the column. `rd_col`/`wr_col` show the starting column of the burst during each of its data cycles.
- R11: While `rst_n` is low, every valid, strobe, last, precharge and error output is low. Reset configuration is CAS 3, additive 0, 4-beat bursts.
- R12: With RL at its maximum of 12, a stream of 4-beat commands every two cycles produces an unbroken run of data cycles, each burst carrying its own column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cas | input | 3 | CAS latency in cycles |
| cfg_add | input | 3 | Additive latency in cycles |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts, 0 = 4-beat |
| cfg_err | output | 1 | Rejected configuration write |
| cmd_valid | input | 1 | READ/WRITE issued this cycle |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_bank | input | 3 | Bank of the command |
| cmd_addr | input | 11 | Bits 9..0 column, bit 10 auto-precharge |
| cmd_err | output | 1 | Rejected command spacing |
| rd_valid | output | 1 | Read data cycle (two beats) |
| rd_dqs_en | output | 1 | Read strobe enable |
| rd_last | output | 1 | Final read data cycle |
| rd_col | output | 10 | Start column of current read burst |
| rd_pre | output | 1 | Auto-precharge request after a read |
| rd_pre_bank | output | 3 | Bank for `rd_pre` |
| wr_valid | output | 1 | Write data cycle (two beats) |
| wr_dqs_en | output | 1 | Write strobe enable |
| wr_last | output | 1 | Final write data cycle |
| wr_col | output | 10 | Start column of current write burst |
| wr_pre | output | 1 | Auto-precharge request after a write |
| wr_pre_bank | output | 3 | Bank for `wr_pre` |

## Verification
The bench sweeps every CAS and additive setting and targets the off-by-one that a design mixing up read and write latency would show: data one cycle early or late in one direction. It truncates 8-beat bursts with and without auto-precharge, where a faulty design would flag a last beat or request precharge for the superseded burst. It also sends commands at one and three cycles of spacing to catch a design that accepts beat-splitting commands or rejects a legal 4-beat spacing. Illegal configuration codes and a maximum-latency stream of overlapping commands round out the set; there a shallow pipeline or a shared slot would drop or merge bursts.

// File: rtl/dlat_sched.sv
module dlat_sched #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 3,
  parameter int AP_BIT = 10,
  parameter int CFG_W  = 3,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 7,
  parameter int AL_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_cas,
  input  logic [CFG_W-1:0]  cfg_add,
  input  logic              cfg_bl8,
  output logic              cfg_err,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [AP_BIT:0]   cmd_addr,
  output logic              cmd_err,
  output logic              rd_valid,
  output logic              rd_dqs_en,
  output logic              rd_last,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_pre,
  output logic [BANK_W-1:0] rd_pre_bank,
  output logic              wr_valid,
  output logic              wr_dqs_en,
  output logic              wr_last,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_pre,
  output logic [BANK_W-1:0] wr_pre_bank
);

  localparam int PIPE = CL_MAX + AL_MAX;
  localparam int LW   = $clog2(PIPE + 1);

  typedef struct packed {
    logic              v;
    logic              ap;
    logic              bl8;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } ent_t;

  logic [CFG_W-1:0] cl_q, al_q;
  logic             bl8_q;
  logic [LW-1:0]    rl;
  logic             cfg_ok;
  ent_t             new_ent;

  logic [1:0]        vld, last, dqs, prq, bad;
  logic [COL_W-1:0]  colv [2];
  logic [BANK_W-1:0] pbk  [2];

  assign cfg_ok = (cfg_cas >= CFG_W'(CL_MIN)) && (cfg_cas <= CFG_W'(CL_MAX)) &&
                  (cfg_add <= CFG_W'(AL_MAX));
  assign rl = LW'(cl_q) + LW'(al_q);
  assign new_ent = '{v: 1'b1, ap: cmd_addr[AP_BIT], bl8: bl8_q,
                     bank: cmd_bank, col: cmd_addr[COL_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q    <= CFG_W'(CL_MIN);
      al_q    <= '0;
      bl8_q   <= 1'b0;
      cfg_err <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cfg_err <= cfg_we && !cfg_ok;
      cmd_err <= |bad;
      if (cfg_we && cfg_ok) begin
        cl_q  <= cfg_cas;
        al_q  <= cfg_add;
        bl8_q <= cfg_bl8;
      end
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    ent_t              slot [1:PIPE];
    logic [LW-1:0]     lat;
    logic [2:0]        gap;
    logic              lbl8, hit, acc;
    logic              act, b_ap, pre;
    logic [2:0]        cnt;
    logic [BANK_W-1:0] b_bank, pre_bank;
    logic [COL_W-1:0]  b_col;

    assign lat = (d == 1) ? rl - LW'(1) : rl;
    assign hit = cmd_valid && (cmd_write == (d == 1));
    assign bad[d] = hit && ((gap == 3'd1) || ((gap == 3'd3) && lbl8));
    assign acc = hit && !bad[d];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 1; i <= PIPE; i++) slot[i] <= '0;
        gap  <= 3'd4;
        lbl8 <= 1'b0;
      end else begin
        for (int i = 1; i < PIPE; i++)
          slot[i] <= (acc && lat == LW'(i)) ? new_ent : slot[i+1];
        slot[PIPE] <= (acc && lat == LW'(PIPE)) ? new_ent : '0;
        gap  <= acc ? 3'd1 : ((gap == 3'd4) ? gap : gap + 3'd1);
        lbl8 <= acc ? bl8_q : lbl8;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act      <= 1'b0;
        cnt      <= '0;
        b_ap     <= 1'b0;
        b_bank   <= '0;
        b_col    <= '0;
        pre      <= 1'b0;
        pre_bank <= '0;
      end else begin
        pre      <= act && (cnt == 3'd1) && b_ap;
        pre_bank <= b_bank;
        if (slot[1].v) begin
          act    <= 1'b1;
          cnt    <= slot[1].bl8 ? 3'd4 : 3'd2;
          b_ap   <= slot[1].ap;
          b_bank <= slot[1].bank;
          b_col  <= slot[1].col;
        end else if (act) begin
          cnt <= cnt - 3'd1;
          act <= (cnt != 3'd1);
        end
      end
    end

    assign vld[d]  = act;
    assign last[d] = act && (cnt == 3'd1);
    assign dqs[d]  = act || slot[1].v;
    assign prq[d]  = pre;
    assign colv[d] = b_col;
    assign pbk[d]  = pre_bank;
  end

  assign rd_valid    = vld[0];
  assign rd_dqs_en   = dqs[0];
  assign rd_last     = last[0];
  assign rd_col      = colv[0];
  assign rd_pre      = prq[0];
  assign rd_pre_bank = pbk[0];
  assign wr_valid    = vld[1];
  assign wr_dqs_en   = dqs[1];
  assign wr_last     = last[1];
  assign wr_col      = colv[1];
  assign wr_pre      = prq[1];
  assign wr_pre_bank = pbk[1];

endmodule

// File: rtl/dlat_sched_chk.sv
module dlat_sched_chk #(
  parameter int CFG_W  = 3,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 7,
  parameter int AL_MAX = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_dqs_en,
  input logic             rd_last,
  input logic             rd_pre,
  input logic             wr_valid,
  input logic             wr_dqs_en,
  input logic             wr_last,
  input logic             wr_pre,
  input logic             cfg_err,
  input logic [CFG_W-1:0] cl_q,
  input logic [CFG_W-1:0] al_q
);

  p_lat_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cl_q >= CFG_W'(CL_MIN) && cl_q <= CFG_W'(CL_MAX) && al_q <= CFG_W'(AL_MAX));

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cl_q == $past(cl_q) && al_q == $past(al_q)));

  p_rd_last_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  p_wr_last_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_valid);

  p_rd_strobe_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_dqs_en);

  p_wr_strobe_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_dqs_en);

  p_rd_preamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_dqs_en));

  p_wr_preamble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(wr_dqs_en));

  p_rd_pre_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pre |-> $past(rd_last));

  p_wr_pre_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pre |-> $past(wr_last));

endmodule

bind dlat_sched dlat_sched_chk #(
  .CFG_W(CFG_W), .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .AL_MAX(AL_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_dqs_en(rd_dqs_en), .rd_last(rd_last), .rd_pre(rd_pre),
  .wr_valid(wr_valid), .wr_dqs_en(wr_dqs_en), .wr_last(wr_last), .wr_pre(wr_pre),
  .cfg_err(cfg_err), .cl_q(cl_q), .al_q(al_q)
);

// File: tb/dlat_sched_test.sv
`timescale 1ns/1ps
module dlat_sched_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_bl8 = 1'b0, cfg_err;
  logic [2:0] cfg_cas = 3'd3, cfg_add = 3'd0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_err;
  logic [2:0] cmd_bank = '0;
  logic [10:0] cmd_addr = '0;
  logic rd_valid, rd_dqs_en, rd_last, rd_pre, wr_valid, wr_dqs_en, wr_last, wr_pre;
  logic [9:0] rd_col, wr_col;
  logic [2:0] rd_pre_bank, wr_pre_bank;

  dlat_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cas(cfg_cas), .cfg_add(cfg_add),
    .cfg_bl8(cfg_bl8), .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_err(cmd_err),
    .rd_valid(rd_valid), .rd_dqs_en(rd_dqs_en), .rd_last(rd_last), .rd_col(rd_col),
    .rd_pre(rd_pre), .rd_pre_bank(rd_pre_bank),
    .wr_valid(wr_valid), .wr_dqs_en(wr_dqs_en), .wr_last(wr_last), .wr_col(wr_col),
    .wr_pre(wr_pre), .wr_pre_bank(wr_pre_bank)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  string phase = "R11";
  int m_cl = 3, m_al = 0;
  bit m_bl8 = 1'b0;
  int last_e [2] = '{-100, -100};
  bit last_b8 [2] = '{1'b0, 1'b0};

  bit ev [int], el [int], edq [int], ep [int], ece [int], efe [int];
  int ecol [int], epb [int];

  function automatic int key(int c, int d);
    return c * 2 + d;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    automatic int k;
    automatic int v, l, q, p, c, b;
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        k = key(cyc, d);
        v = d ? int'(wr_valid) : int'(rd_valid);
        l = d ? int'(wr_last) : int'(rd_last);
        q = d ? int'(wr_dqs_en) : int'(rd_dqs_en);
        p = d ? int'(wr_pre) : int'(rd_pre);
        c = d ? int'(wr_col) : int'(rd_col);
        b = d ? int'(wr_pre_bank) : int'(rd_pre_bank);
        chk(d ? "wr valid" : "rd valid", v, int'(ev.exists(k)));
        chk(d ? "R5 wr_last" : "R5 rd_last", l, int'(el.exists(k)));
        chk(d ? "R6 wr_dqs_en" : "R6 rd_dqs_en", q, int'(edq.exists(k)));
        chk(d ? "R9 wr_pre" : "R9 rd_pre", p, int'(ep.exists(k)));
        if (ev.exists(k)) chk(d ? "R10 wr_col" : "R10 rd_col", c, ecol[k]);
        if (ep.exists(k)) chk(d ? "R9 wr_pre_bank" : "R9 rd_pre_bank", b, epb[k]);
      end
      chk("R8 cmd_err", int'(cmd_err), int'(ece.exists(cyc)));
      chk("R3 cfg_err", int'(cfg_err), int'(efe.exists(cyc)));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(bit d, int bk, int col, bit ap);
    int e, g, lat, s, n;
    e = cyc + 1;
    g = e - last_e[d];
    if (g == 1 || (g == 3 && last_b8[d])) begin
      ece[e] = 1'b1;
    end else begin
      lat = m_al + m_cl - int'(d);
      s = e + lat;
      n = m_bl8 ? 4 : 2;
      if (ev.exists(key(s, d))) begin
        for (int c = s; c < s + 6; c++) begin
          ev.delete(key(c, d)); el.delete(key(c, d)); ep.delete(key(c, d));
        end
      end
      for (int c = s; c < s + n; c++) begin
        ev[key(c, d)] = 1'b1; ecol[key(c, d)] = col; edq[key(c, d)] = 1'b1;
      end
      edq[key(s - 1, d)] = 1'b1;
      el[key(s + n - 1, d)] = 1'b1;
      if (ap) begin ep[key(s + n, d)] = 1'b1; epb[key(s + n, d)] = bk; end
      last_e[d] = e;
      last_b8[d] = m_bl8;
    end
    cmd_valid = 1'b1; cmd_write = d; cmd_bank = 3'(bk); cmd_addr = {ap, 10'(col)};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfgset(int cas, int add, bit b8);
    int e;
    e = cyc + 1;
    if (cas >= 3 && cas <= 7 && add >= 0 && add <= 5) begin
      m_cl = cas; m_al = add; m_bl8 = b8;
    end else begin
      efe[e] = 1'b1;
    end
    cfg_we = 1'b1; cfg_cas = 3'(cas); cfg_add = 3'(add); cfg_bl8 = b8;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R11";
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 wr_valid", int'(wr_valid), 0);
    chk("R11 dqs_en", int'(rd_dqs_en | wr_dqs_en), 0);
    chk("R11 last", int'(rd_last | wr_last), 0);
    chk("R11 pre", int'(rd_pre | wr_pre), 0);
    chk("R11 errors", int'(cmd_err | cfg_err), 0);
    rst_n = 1'b1;
    idle(3);

    phase = "R5";
    issue(0, 2, 5, 0); idle(4); issue(1, 3, 9, 0); idle(20);

    phase = "R1";
    for (int cas = 3; cas <= 7; cas++) begin
      cfgset(cas, 0, 0); issue(0, 1, cas * 3, 0); idle(16);
    end

    phase = "R2";
    for (int add = 0; add <= 5; add++) begin
      cfgset(4, add, 0); issue(0, 4, add, 0); idle(2); issue(1, 4, add + 40, 0); idle(18);
    end

    phase = "R4";
    cfgset(3, 0, 0); issue(1, 7, 100, 0); idle(2); issue(1, 6, 101, 0); idle(15);

    phase = "R3";
    cfgset(2, 0, 1); cfgset(5, 6, 1); cfgset(0, 7, 1);
    issue(0, 0, 33, 0); idle(12);

    phase = "R5";
    cfgset(3, 1, 1); issue(0, 2, 200, 0); idle(10); issue(1, 2, 201, 0); idle(12);

    phase = "R7";
    issue(0, 5, 300, 1); idle(1); issue(0, 5, 310, 0); idle(14);
    issue(1, 1, 320, 1); idle(1); issue(1, 1, 330, 1); idle(14);

    phase = "R8";
    issue(0, 3, 400, 0); issue(0, 3, 401, 0); idle(14);
    issue(0, 3, 402, 0); idle(2); issue(0, 3, 403, 0); idle(14);
    issue(1, 4, 404, 0); issue(1, 4, 405, 0); idle(14);
    cfgset(3, 1, 0);
    issue(0, 6, 406, 0); idle(2); issue(0, 6, 407, 0); idle(14);

    phase = "R9";
    issue(0, 5, 500, 1); idle(10); issue(1, 6, 501, 1); idle(12);
    issue(0, 7, 510, 1); idle(1); issue(0, 2, 512, 1); idle(14);

    phase = "R10";
    issue(0, 0, 1023, 0); idle(1); issue(0, 0, 0, 0); idle(12);

    phase = "R12";
    cfgset(7, 5, 0);
    for (int i = 0; i < 6; i++) begin issue(0, i, 600 + i, i == 5); idle(1); end
    idle(20);
    for (int i = 0; i < 6; i++) begin issue(1, i, 700 + i, i == 5); idle(1); end
    idle(20);
    cfgset(7, 5, 1);
    for (int i = 0; i < 3; i++) begin issue(0, 7 - i, 800 + i, i == 2); idle(3); end
    idle(24);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish (cycle %0d)", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule